// File: doc/BRIEF.md
# Lookahead Adder-Subtractor with Condition Flags

This block is a purely combinational 32-bit integer add/subtract unit. It takes two operands and a mode bit. With the mode low it returns the sum. With the mode high it returns the difference in two's complement. Each bit forms a generate term and a propagate term. Every carry is then produced as one flat sum of products over all lower generate and propagate terms and the initial carry. No carry travels bit by bit through the bits below it.

Subtraction works by inverting the second operand with one XOR gate per bit and setting the initial carry to one. Both actions are driven by the mode bit. The unit also reports four condition flags: negative, zero, carry-out and signed overflow. A surrounding execution stage can use these flags for branch decisions or comparisons. There is no external carry input and no register anywhere in the block.

Top module: `addsub_cla_top`

## Requirements
- R1: With `subMode` = 0, `sumOut` equals (`opA` + `opB`) modulo 2^32.
- R2: With `subMode` = 1, `sumOut` equals (`opA` − `opB`) modulo 2^32, formed as `opA` + ~`opB` + 1.
- R3: `flagC` is bit 32 of the 33-bit sum of `opA`, the conditioned second operand and the initial carry. In subtract mode this means `flagC` = 1 exactly when `opA` ≥ `opB` as unsigned values, that is, when no borrow occurs.
- R4: `flagV` is 1 exactly when `opA` and the conditioned second operand have equal bit 31 and `sumOut[31]` differs from it. This equals the carry into bit 31 XOR the carry out of bit 31.
- R5: `flagN` equals `sumOut[31]`.
- R6: `flagZ` is 1 exactly when all 32 bits of `sumOut` are 0.
- R7: A carry generated at bit 0, or injected as the initial carry, reaches the carry-out through a full 32-bit propagate run. For example, 0xFFFFFFFF + 1 gives `sumOut` = 0 with `flagC` = 1, and 0 − 0 gives `sumOut` = 0 with `flagC` = 1.
- R8: Signed boundaries are handled. 0x7FFFFFFF + 1 gives 0x80000000 with `flagV` = 1, `flagN` = 1 and `flagC` = 0. 0x80000000 − 1 gives 0x7FFFFFFF with `flagV` = 1, `flagN` = 0 and `flagC` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand (minuend in subtract mode) |
| opB | input | 32 | Second operand (subtrahend in subtract mode) |
| subMode | input | 1 | 0 selects addition, 1 selects subtraction |
| sumOut | output | 32 | Sum or difference |
| flagN | output | 1 | Negative flag, the result sign bit |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry out of bit 31 (no-borrow in subtract mode) |
| flagV | output | 1 | Signed overflow |

## Verification
The checker evaluates immediate properties whenever the combinational outputs settle. These properties assume that every input bit holds a defined 0 or 1, because an unknown mode bit would make the reference sum meaningless. The bench only ever applies fully specified operand words and an explicit mode value. It changes the inputs on one clock edge and reads the outputs on the opposite edge, so the checker and the bench always see settled values.

// File: rtl/addsub_cla_pkg.sv
package addsub_cla_pkg;

  // Strobes sent from the mode decoder to the arithmetic datapath
  typedef struct packed {
    logic invertB;   // complement the second operand
    logic carryIn;   // initial carry into bit 0
  } ctrlStrobes_t;

endpackage

// File: rtl/addsub_cla_ctrl.sv
module addsub_cla_ctrl
  import addsub_cla_pkg::*;
(
  input  logic         subMode,
  output ctrlStrobes_t strobes
);

  // Subtraction = add inverted operand plus one, both from the same select
  always_comb begin
    strobes.invertB = subMode;
    strobes.carryIn = subMode;
  end

endmodule

// File: rtl/addsub_cla_lookahead.sv
module addsub_cla_lookahead #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] genBits,
  input  logic [WIDTH-1:0] propBits,
  input  logic             carryZero,
  output logic [WIDTH:0]   carries
);

  assign carries[0] = carryZero;

  // Each carry is an independent sum of products over lower terms:
  // c[i] = g[i-1] | p[i-1]g[i-2] | ... | p[i-1]..p[1]g[0] | p[i-1]..p[0]c0
  for (genvar i = 1; i <= WIDTH; i++) begin : g_carry
    logic termOr;
    logic chainAnd;
    always_comb begin
      termOr   = 1'b0;
      chainAnd = 1'b1;
      for (int j = i - 1; j >= 0; j--) begin
        termOr   = termOr | (chainAnd & genBits[j]);
        chainAnd = chainAnd & propBits[j];
      end
      termOr = termOr | (chainAnd & carryZero);
    end
    assign carries[i] = termOr;
  end

endmodule

// File: rtl/addsub_cla_datapath.sv
module addsub_cla_datapath
  import addsub_cla_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  ctrlStrobes_t     strobes,
  output logic [WIDTH-1:0] sumOut,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] condB;
  logic [WIDTH-1:0] genBits;
  logic [WIDTH-1:0] propBits;
  logic [WIDTH:0]   carries;

  // Operand conditioning: one XOR per bit against the invert strobe
  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign condB[k]    = opB[k] ^ strobes.invertB;
    assign genBits[k]  = opA[k] & condB[k];
    assign propBits[k] = opA[k] | condB[k];
    assign sumOut[k]   = opA[k] ^ condB[k] ^ carries[k];
  end

  addsub_cla_lookahead #(.WIDTH(WIDTH)) lookahead_i (
    .genBits  (genBits),
    .propBits (propBits),
    .carryZero(strobes.carryIn),
    .carries  (carries)
  );

  assign flagC = carries[WIDTH];
  assign flagV = carries[WIDTH] ^ carries[MSB];
  assign flagN = sumOut[MSB];
  assign flagZ = ~|sumOut;

endmodule

// File: rtl/addsub_cla_top.sv
module addsub_cla_top
  import addsub_cla_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             subMode,
  output logic [WIDTH-1:0] sumOut,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV
);

  ctrlStrobes_t strobes;

  addsub_cla_ctrl ctrl_i (
    .subMode(subMode),
    .strobes(strobes)
  );

  addsub_cla_datapath #(.WIDTH(WIDTH)) datapath_i (
    .opA    (opA),
    .opB    (opB),
    .strobes(strobes),
    .sumOut (sumOut),
    .flagN  (flagN),
    .flagZ  (flagZ),
    .flagC  (flagC),
    .flagV  (flagV)
  );

endmodule

// File: rtl/addsub_cla_chk.sv
module addsub_cla_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             subMode,
  input logic [WIDTH-1:0] sumOut,
  input logic             flagN,
  input logic             flagZ,
  input logic             flagC,
  input logic             flagV
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] effB;
  logic [WIDTH:0]   wideSum;

  always_comb begin
    effB    = subMode ? ~opB : opB;
    wideSum = {1'b0, opA} + {1'b0, effB} + {{WIDTH{1'b0}}, subMode};
  end

  always_comb begin
    if (!subMode) begin
      AST_ADD_RESULT: assert (sumOut == opA + opB) else $error("add result"); // R1
    end else begin
      AST_SUB_RESULT: assert (sumOut == opA - opB) else $error("sub result"); // R2
      AST_NO_BORROW: assert (flagC == (opA >= opB)) else $error("borrow"); // R3
    end
    AST_CARRY_OUT: assert (flagC == wideSum[WIDTH]) else $error("carry"); // R3
    AST_SIGNED_OVF: assert (flagV == ((opA[MSB] == effB[MSB]) && (sumOut[MSB] != opA[MSB])))
      else $error("overflow"); // R4
    AST_NEG_FLAG: assert (flagN == sumOut[MSB]) else $error("negative"); // R5
    AST_ZERO_FLAG: assert (flagZ == (sumOut == '0)) else $error("zero"); // R6
  end

endmodule

bind addsub_cla_top addsub_cla_chk #(.WIDTH(WIDTH)) chk_i (
  .opA    (opA),
  .opB    (opB),
  .subMode(subMode),
  .sumOut (sumOut),
  .flagN  (flagN),
  .flagZ  (flagZ),
  .flagC  (flagC),
  .flagV  (flagV)
);

// File: tb/addsub_cla_top_tb_top.sv
`timescale 1ns/1ps
module addsub_cla_top_tb_top;

  logic        clk = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        subMode = 1'b0;
  logic [31:0] sumOut;
  logic        flagN, flagZ, flagC, flagV;

  int numChecks = 0;
  int numFails  = 0;
  bit doneFlag  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  addsub_cla_top dut_i (
    .opA(opA), .opB(opB), .subMode(subMode),
    .sumOut(sumOut), .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV)
  );

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    numChecks++;
    if (act !== exp) begin
      numFails++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // Apply on a rising edge, sample on the following falling edge
  task automatic applyOp(input logic [31:0] a, input logic [31:0] b, input logic m);
    @(posedge clk);
    opA = a; opB = b; subMode = m;
    @(negedge clk);
  endtask

  // Independent 33-bit model derived from the requirements
  task automatic checkRef(input string req, input logic [31:0] a, input logic [31:0] b, input logic m);
    logic [32:0] full;
    logic [31:0] bb;
    logic        v;
    bb   = m ? ~b : b;
    full = m ? ({1'b0, a} - {1'b0, b} + 33'h1_0000_0000) : ({1'b0, a} + {1'b0, b});
    v    = (a[31] == bb[31]) && (full[31] != a[31]);
    applyOp(a, b, m);
    cmp(m ? "R2" : "R1", "sumOut", sumOut, full[31:0]);
    cmp("R3", {req, " flagC"}, {31'b0, flagC}, {31'b0, full[32]});
    cmp("R4", {req, " flagV"}, {31'b0, flagV}, {31'b0, v});
    cmp("R5", {req, " flagN"}, {31'b0, flagN}, {31'b0, full[31]});
    cmp("R6", {req, " flagZ"}, {31'b0, flagZ}, {31'b0, (full[31:0] == 32'h0)});
  endtask

  task automatic testIdle();
    applyOp(32'h0, 32'h0, 1'b0);
    cmp("R6", "idle zero flag", {31'b0, flagZ}, 32'h1);
    cmp("R1", "idle sum", sumOut, 32'h0);
  endtask

  task automatic testRandomAdd();
    for (int i = 0; i < 300; i++) checkRef("R1", $urandom, $urandom, 1'b0);
  endtask

  task automatic testRandomSub();
    for (int i = 0; i < 300; i++) checkRef("R2", $urandom, $urandom, 1'b1);
    for (int i = 0; i < 50; i++) begin
      logic [31:0] x;
      x = $urandom;
      checkRef("R3", x, x, 1'b1);  // equal operands: zero, no borrow
    end
  endtask

  task automatic testCarryChain();
    applyOp(32'hFFFF_FFFF, 32'h1, 1'b0);
    cmp("R7", "ffffffff+1 sum", sumOut, 32'h0);
    cmp("R7", "ffffffff+1 C", {31'b0, flagC}, 32'h1);
    cmp("R7", "ffffffff+1 Z", {31'b0, flagZ}, 32'h1);
    cmp("R7", "ffffffff+1 V", {31'b0, flagV}, 32'h0);
    applyOp(32'h0, 32'h0, 1'b1);
    cmp("R7", "0-0 sum", sumOut, 32'h0);
    cmp("R7", "0-0 C", {31'b0, flagC}, 32'h1);
    cmp("R7", "0-0 Z", {31'b0, flagZ}, 32'h1);
    applyOp(32'h0, 32'h1, 1'b1);
    cmp("R3", "0-1 sum", sumOut, 32'hFFFF_FFFF);
    cmp("R3", "0-1 borrow C", {31'b0, flagC}, 32'h0);
    cmp("R5", "0-1 N", {31'b0, flagN}, 32'h1);
  endtask

  task automatic testSignedEdges();
    applyOp(32'h7FFF_FFFF, 32'h1, 1'b0);
    cmp("R8", "7fffffff+1 sum", sumOut, 32'h8000_0000);
    cmp("R8", "7fffffff+1 V", {31'b0, flagV}, 32'h1);
    cmp("R8", "7fffffff+1 N", {31'b0, flagN}, 32'h1);
    cmp("R8", "7fffffff+1 C", {31'b0, flagC}, 32'h0);
    applyOp(32'h8000_0000, 32'h1, 1'b1);
    cmp("R8", "80000000-1 sum", sumOut, 32'h7FFF_FFFF);
    cmp("R8", "80000000-1 V", {31'b0, flagV}, 32'h1);
    cmp("R8", "80000000-1 N", {31'b0, flagN}, 32'h0);
    cmp("R8", "80000000-1 C", {31'b0, flagC}, 32'h1);
    applyOp(32'h8000_0000, 32'h8000_0000, 1'b0);
    cmp("R4", "min+min V", {31'b0, flagV}, 32'h1);
    cmp("R6", "min+min Z", {31'b0, flagZ}, 32'h1);
  endtask

  initial begin
    testIdle();
    testRandomAdd();
    testRandomSub();
    testCarryChain();
    testSignedEdges();
    doneFlag = 1'b1;
  end

  initial begin
    fork
      begin
        wait (doneFlag);
      end
      begin
        repeat (100000) @(posedge clk);
        numChecks++;
        numFails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", numChecks, numFails);
    $finish;
  end

endmodule